// File: doc/BRIEF.md
# Decode-Stage Operand Hazard Resolver

This block sits beside the decode stage of a five-stage integer pipeline. Each cycle it looks at the two source register numbers of the instruction being decoded. It compares them with the destinations of the older instructions now in execute and memory. From that comparison it decides, for each operand, whether the value read from the register file is current. If it is not, the block either selects a bypass path or holds the front of the pipeline for one cycle. Register values are needed by the end of decode. A producer that has already reached write-back is never a hazard, because its register file write is visible to a read in the same cycle. For that reason the write-back stage is not an input.

Each producer stage supplies both of its register fields and a flag that selects which of the two is the destination. Each producer also supplies a write-enable. The execute stage additionally supplies a load flag, because a load has no result until its memory access ends. A mode input chooses the strategy: no handling, stall only, or bypass with a stall for loads. A pipeline-enable input forces the no-handling behaviour when the core runs one instruction at a time. Every output is combinational from the inputs. The clock and reset inputs are used only to time the built-in property checks.

Top module: `hazard_unit`

## Requirements
- R1: When `pipelined` is 0 or `mode` is 0, `stall` and `bubble` are 0 and both selects are 0, whatever the other inputs are.
- R2: A producer whose destination is register 0 never causes a stall or a bypass.
- R3: A producer's destination is its rt field when its `*_dst_is_rt` flag is 1 and its rd field otherwise. A producer with its write flag at 0 (for example a store) creates no dependency.
- R4: In a bypass mode (`mode[1]`=1), an operand matching a non-load producer in execute gets select 1 (execute path).
- R5: In a bypass mode, an operand matching a load in execute raises `stall` and `bubble`, and both selects are 0 during that stall.
- R6: In a bypass mode, an operand matching only the memory-stage producer gets select 2 (memory path).
- R7: When both producers match the same operand, the execute-stage producer wins (select 1).
- R8: An operand whose use flag is 0 never matches.
- R9: In stall-only mode (`mode`=1), any match against execute or memory raises `stall`, and both selects stay 0.
- R10: The two operands are resolved independently, so one can take the execute path while the other takes the memory path.
- R11: `mode`=3 behaves exactly like `mode`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for property checks only |
| rst_n | input | 1 | Active-low reset for property checks |
| mode | input | 2 | 0 none, 1 stall only, 2 or 3 bypass with load stall |
| pipelined | input | 1 | 0 forces the no-handling behaviour |
| id_rs | input | RW | First source register of the decode instruction |
| id_rt | input | RW | Second source register of the decode instruction |
| id_rs_used | input | 1 | First source is read |
| id_rt_used | input | 1 | Second source is read |
| ex_rd | input | RW | rd field in execute |
| ex_rt | input | RW | rt field in execute |
| ex_dst_is_rt | input | 1 | Execute destination is rt |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | RW | rd field in memory stage |
| mem_rt | input | RW | rt field in memory stage |
| mem_dst_is_rt | input | 1 | Memory-stage destination is rt |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| fwd_a | output | 2 | First operand source: 0 register file, 1 execute, 2 memory |
| fwd_b | output | 2 | Second operand source, same encoding |
| stall | output | 1 | Hold PC and the fetch/decode register |
| bubble | output | 1 | Insert a no-op into execute |

## Verification
The bench targets a load in execute that collides with an operand. A unit that bypassed there would feed an address in place of loaded data, and a unit that also bypassed during the stall would show a non-zero select. It places the same register in both producer stages. Picking the memory producer there would return a stale value. It also drives writes to register 0, producers with writes disabled, unused operands and destination selection by rt. A faulty unit would stall or bypass for dependencies that do not exist, or miss the real destination of an immediate-format producer.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          pipelined,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic          id_rs_used,
  input  logic          id_rt_used,
  input  logic [RW-1:0] ex_rd,
  input  logic [RW-1:0] ex_rt,
  input  logic          ex_dst_is_rt,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic [RW-1:0] mem_rt,
  input  logic          mem_dst_is_rt,
  input  logic          mem_wr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          bubble
);

  localparam logic [1:0] SEL_RF  = 2'd0;
  localparam logic [1:0] SEL_EX  = 2'd1;
  localparam logic [1:0] SEL_MEM = 2'd2;

  logic [1:0]    eff_mode;
  logic          byp_on, stall_only;
  logic [RW-1:0] ex_dst, mem_dst;
  logic          ex_live, mem_live;
  logic          a_ex, a_mem, b_ex, b_mem;
  logic          load_hit;

  assign eff_mode   = pipelined ? mode : 2'd0;
  assign byp_on     = eff_mode[1];
  assign stall_only = (eff_mode == 2'd1);

  assign ex_dst   = ex_dst_is_rt  ? ex_rt  : ex_rd;
  assign mem_dst  = mem_dst_is_rt ? mem_rt : mem_rd;
  assign ex_live  = ex_wr  && (ex_dst  != '0);
  assign mem_live = mem_wr && (mem_dst != '0);

  assign a_ex  = id_rs_used && ex_live  && (id_rs == ex_dst);
  assign a_mem = id_rs_used && mem_live && (id_rs == mem_dst);
  assign b_ex  = id_rt_used && ex_live  && (id_rt == ex_dst);
  assign b_mem = id_rt_used && mem_live && (id_rt == mem_dst);

  assign load_hit = ex_load && (a_ex || b_ex);

  assign stall  = (stall_only && (a_ex || a_mem || b_ex || b_mem))
               || (byp_on && load_hit);
  assign bubble = stall;

  always_comb begin
    fwd_a = SEL_RF;
    fwd_b = SEL_RF;
    if (byp_on && !stall) begin
      if (a_ex)       fwd_a = SEL_EX;
      else if (a_mem) fwd_a = SEL_MEM;
      if (b_ex)       fwd_b = SEL_EX;
      else if (b_mem) fwd_b = SEL_MEM;
    end
  end

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipelined || mode == 2'd0) |-> (!stall && !bubble && fwd_a == 2'd0 && fwd_b == 2'd0));

  p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0 && id_rt == '0) |-> (!stall && fwd_a == 2'd0 && fwd_b == 2'd0));

  p_ex_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'd1) |-> (ex_wr && !ex_load && id_rs_used
                         && id_rs == (ex_dst_is_rt ? ex_rt : ex_rd)));

  p_load_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipelined && mode[1] && ex_wr && ex_load && id_rs_used && id_rs != '0
     && id_rs == (ex_dst_is_rt ? ex_rt : ex_rd)) |-> (stall && bubble && fwd_a == 2'd0 && fwd_b == 2'd0));

  p_mem_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b == 2'd2) |-> (mem_wr && id_rt_used
                         && id_rt == (mem_dst_is_rt ? mem_rt : mem_rd)));

  p_stall_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pipelined && mode == 2'd1) |-> (fwd_a == 2'd0 && fwd_b == 2'd0));

endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
  localparam int RW = 5;

  typedef struct packed {
    logic [7:0]    req;
    logic [1:0]    mode;
    logic          pipe;
    logic [RW-1:0] rs, rt;
    logic          urs, urt;
    logic [RW-1:0] exrd, exrt;
    logic          exsel, exwr, exld;
    logic [RW-1:0] memrd, memrt;
    logic          memsel, memwr;
    logic [1:0]    fa, fb;
    logic          st;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{8'd1, 2'd0,1'b1, 5'd3,5'd4, 1'b1,1'b1, 5'd3,5'd0, 1'b0,1'b1,1'b0, 5'd4,5'd0, 1'b0,1'b1, 2'd0,2'd0,1'b0}, // R1 mode none
    '{8'd1, 2'd2,1'b0, 5'd3,5'd4, 1'b1,1'b1, 5'd3,5'd0, 1'b0,1'b1,1'b0, 5'd4,5'd0, 1'b0,1'b1, 2'd0,2'd0,1'b0}, // R1 not pipelined
    '{8'd4, 2'd2,1'b1, 5'd3,5'd9, 1'b1,1'b1, 5'd3,5'd0, 1'b0,1'b1,1'b0, 5'd0,5'd0, 1'b0,1'b0, 2'd1,2'd0,1'b0}, // R4
    '{8'd3, 2'd2,1'b1, 5'd3,5'd9, 1'b1,1'b1, 5'd3,5'd9, 1'b1,1'b1,1'b0, 5'd0,5'd0, 1'b0,1'b0, 2'd0,2'd1,1'b0}, // R3 rt dest in EX
    '{8'd3, 2'd2,1'b1, 5'd3,5'd9, 1'b1,1'b1, 5'd3,5'd0, 1'b0,1'b0,1'b0, 5'd0,5'd0, 1'b0,1'b0, 2'd0,2'd0,1'b0}, // R3 store, no write
    '{8'd5, 2'd2,1'b1, 5'd5,5'd8, 1'b1,1'b1, 5'd0,5'd5, 1'b1,1'b1,1'b1, 5'd0,5'd0, 1'b0,1'b0, 2'd0,2'd0,1'b1}, // R5 load on rs
    '{8'd5, 2'd2,1'b1, 5'd8,5'd5, 1'b1,1'b1, 5'd0,5'd5, 1'b1,1'b1,1'b1, 5'd0,5'd0, 1'b0,1'b0, 2'd0,2'd0,1'b1}, // R5 load on rt
    '{8'd6, 2'd2,1'b1, 5'd7,5'd8, 1'b1,1'b1, 5'd0,5'd0, 1'b0,1'b0,1'b0, 5'd7,5'd0, 1'b0,1'b1, 2'd2,2'd0,1'b0}, // R6
    '{8'd3, 2'd2,1'b1, 5'd8,5'd7, 1'b1,1'b1, 5'd0,5'd0, 1'b0,1'b0,1'b0, 5'd9,5'd7, 1'b1,1'b1, 2'd0,2'd2,1'b0}, // R3 rt dest in MEM
    '{8'd7, 2'd2,1'b1, 5'd6,5'd8, 1'b1,1'b1, 5'd6,5'd0, 1'b0,1'b1,1'b0, 5'd6,5'd0, 1'b0,1'b1, 2'd1,2'd0,1'b0}, // R7
    '{8'd10,2'd2,1'b1, 5'd6,5'd7, 1'b1,1'b1, 5'd6,5'd0, 1'b0,1'b1,1'b0, 5'd7,5'd0, 1'b0,1'b1, 2'd1,2'd2,1'b0}, // R10
    '{8'd8, 2'd2,1'b1, 5'd6,5'd7, 1'b0,1'b0, 5'd6,5'd0, 1'b0,1'b1,1'b0, 5'd7,5'd0, 1'b0,1'b1, 2'd0,2'd0,1'b0}, // R8
    '{8'd9, 2'd1,1'b1, 5'd6,5'd8, 1'b1,1'b1, 5'd6,5'd0, 1'b0,1'b1,1'b0, 5'd0,5'd0, 1'b0,1'b0, 2'd0,2'd0,1'b1}, // R9 EX match
    '{8'd9, 2'd1,1'b1, 5'd6,5'd7, 1'b1,1'b1, 5'd0,5'd0, 1'b0,1'b0,1'b0, 5'd7,5'd0, 1'b0,1'b1, 2'd0,2'd0,1'b1}, // R9 MEM match
    '{8'd9, 2'd1,1'b1, 5'd6,5'd7, 1'b1,1'b1, 5'd3,5'd0, 1'b0,1'b1,1'b0, 5'd4,5'd0, 1'b0,1'b1, 2'd0,2'd0,1'b0}, // R9 no match
    '{8'd2, 2'd2,1'b1, 5'd0,5'd0, 1'b1,1'b1, 5'd0,5'd0, 1'b0,1'b1,1'b0, 5'd0,5'd0, 1'b0,1'b1, 2'd0,2'd0,1'b0}, // R2
    '{8'd11,2'd3,1'b1, 5'd6,5'd7, 1'b1,1'b1, 5'd6,5'd0, 1'b0,1'b1,1'b0, 5'd7,5'd0, 1'b0,1'b1, 2'd1,2'd2,1'b0}, // R11
    '{8'd5, 2'd2,1'b1, 5'd6,5'd7, 1'b1,1'b1, 5'd6,5'd0, 1'b0,1'b1,1'b1, 5'd7,5'd0, 1'b0,1'b1, 2'd0,2'd0,1'b1}, // R5 clears MEM select
    '{8'd1, 2'd0,1'b1, 5'd6,5'd7, 1'b1,1'b1, 5'd6,5'd0, 1'b0,1'b1,1'b1, 5'd7,5'd0, 1'b0,1'b1, 2'd0,2'd0,1'b0}  // R1 load ignored
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic pipelined = 1'b0;
  logic [RW-1:0] id_rs = '0, id_rt = '0, ex_rd = '0, ex_rt = '0, mem_rd = '0, mem_rt = '0;
  logic id_rs_used = 1'b0, id_rt_used = 1'b0, ex_dst_is_rt = 1'b0, ex_wr = 1'b0, ex_load = 1'b0;
  logic mem_dst_is_rt = 1'b0, mem_wr = 1'b0;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hazard_unit #(.RW(RW)) i_hazard_unit (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pipelined(pipelined),
    .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
    .ex_rd(ex_rd), .ex_rt(ex_rt), .ex_dst_is_rt(ex_dst_is_rt), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_rt(mem_rt), .mem_dst_is_rt(mem_dst_is_rt), .mem_wr(mem_wr),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble));

  task automatic drive(input vec_t v);
    @(negedge clk);
    mode = v.mode; pipelined = v.pipe; id_rs = v.rs; id_rt = v.rt;
    id_rs_used = v.urs; id_rt_used = v.urt;
    ex_rd = v.exrd; ex_rt = v.exrt; ex_dst_is_rt = v.exsel; ex_wr = v.exwr; ex_load = v.exld;
    mem_rd = v.memrd; mem_rt = v.memrt; mem_dst_is_rt = v.memsel; mem_wr = v.memwr;
    #1;
  endtask

  task automatic check(input int req, input logic [1:0] fa, input logic [1:0] fb, input logic st);
    checks++;
    if (fwd_a !== fa || fwd_b !== fb || stall !== st || bubble !== st) begin
      errors++;
      $display("FAIL R%0d: got fa=%0d fb=%0d stall=%0b bubble=%0b, expected fa=%0d fb=%0d stall=%0b",
               req, fwd_a, fwd_b, stall, bubble, fa, fb, st);
    end
  endtask

  initial begin
    #1;
    check(1, 2'd0, 2'd0, 1'b0);  // R1 reset state, mode none
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    foreach (TBL[i]) begin
      drive(TBL[i]);
      check(int'(TBL[i].req), TBL[i].fa, TBL[i].fb, TBL[i].st);
    end
    // R2 sweep: writes to register 0 from both stages, every mode, with and without load
    for (int m = 1; m < 4; m++) begin
      for (int ld = 0; ld < 2; ld++) begin
        vec_t v;
        v = '0;
        v.req = 8'd2; v.mode = 2'(m); v.pipe = 1'b1; v.urs = 1'b1; v.urt = 1'b1;
        v.exwr = 1'b1; v.exld = 1'(ld); v.exsel = 1'(ld); v.memwr = 1'b1; v.memsel = 1'b1;
        drive(v);
        check(2, 2'd0, 2'd0, 1'b0);
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no completion, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule